// File: doc/BRIEF.md
# Pausable Seconds Tally Controller

This block counts elapsed seconds as a six-digit BCD value. A free-running phase timer divides the system clock (50 MHz by default) into one-second periods. At the end of each period the units digit steps by one, and a digit that passes nine wraps to zero and carries into the next digit. Two push buttons steer it. The pause button flips between counting and frozen. The add button starts an automatic sequence: counting is held for one full second, ten is added to the tally, and then the block resumes the mode it was in before the press.

Both buttons are sampled once every debounce interval, 20 ms by default. A press is recognised only when one sample shows the button released and the next sample shows it pressed. Four indicator lamps show the mode. While counting, a single lit lamp walks across them in quarter-second steps. While frozen, or while the add sequence runs, all four lamps blink together. The block outputs the digit values only; the seven-segment decoding and the display scanning are left to the logic that follows it.

Top module: `sec_tally`

## Requirements
- R1: While counting, the tally increments by one every TICK_CYCLES clocks. The units digit sits in `count_bcd[3:0]`, each higher digit takes the next four bits, every digit stays within 0..9, and a digit that passes 9 returns to 0 and carries one into the next digit.
- R2: While `rst_n` is low, every digit and every lamp bit is zero, the block is in counting mode and no add sequence is pending.
- R3: Each key is sampled once every SAMPLE_CYCLES clocks. A press is one sample at the released level followed by the next sample at the pressed level. A pulse that lies wholly between two samples has no effect. The default pressed level is low (KEY_ACTIVE_LOW=1).
- R4: Outside an add sequence, each press of `key_pause` toggles between counting and frozen. While frozen, the digits do not change.
- R5: While counting, the lamps are one-hot. Bit 0 is lit in the first quarter of the timer period, bit 1 in the second, bit 2 in the third and bit 3 in the last, and each lamp output lags the timer by one clock.
- R6: While frozen or during an add sequence, the lamps are 4'b0000 in the first half of the timer period and 4'b1111 in the second half.
- R7: A press of `key_add` restarts the timer and holds the tally for TICK_CYCLES clocks. At the end of that hold, ten is added in a single clock (tens digit plus one, carrying upward), no one-step increment occurs in that clock, and the mode from before the press is restored.
- R8: During an add sequence, a further `key_add` press is ignored. Each `key_pause` press is counted, and an odd number of presses toggles the mode when the sequence ends.
- R9: Both the one-step increment and the add of ten wrap modulo 10^DIGITS.
- R10: After an add sequence, the timer starts from zero, so the next one-step increment comes a full TICK_CYCLES clocks after the add.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| key_pause | input | 1 | Pause/resume push button, raw level |
| key_add | input | 1 | Add-ten push button, raw level |
| count_bcd | output | 4*DIGITS | BCD tally, units digit in the lowest nibble |
| led | output | 4 | Mode indicator lamps |

## Verification
The mode bits and the phase timer are the only hidden state, and both show at the lamp outputs within one clock. A wrong frozen or hold flag flips the lamps between the walking pattern and the blink, and a phase that is off moves the quarter boundaries. A wrong digit shows on `count_bcd` at once. A slip in the timer restart after an add, or a lost deferred pause press, surfaces within one timer period as an increment in the wrong clock. The bench compares every clock against a behavioural model. It uses short timer and sample periods, and it runs a second two-digit instance so that the wrap around 10^DIGITS is reached.

// File: rtl/sec_tally_pkg.sv
package sec_tally_pkg;
   typedef enum logic {
      SEQ_FREE = 1'b0,
      SEQ_HOLD = 1'b1
   } seq_e;

   localparam logic [3:0] LAMPS_OFF = 4'b0000;
   localparam logic [3:0] LAMPS_ON  = 4'b1111;
endpackage

// File: rtl/sec_tally_keysamp.sv
module sec_tally_keysamp #(
   parameter int SAMPLE_CYCLES  = 1_000_000,
   parameter bit KEY_ACTIVE_LOW = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic key_raw,
   output logic press
);
   localparam int SW = $clog2(SAMPLE_CYCLES);
   localparam logic [SW-1:0] S_LAST = SW'(SAMPLE_CYCLES - 1);

   logic          key_up;
   logic          held_q;
   logic [SW-1:0] scnt_q;

   generate
      if (KEY_ACTIVE_LOW) begin : g_low
         assign key_up = key_raw;
      end else begin : g_high
         assign key_up = ~key_raw;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scnt_q <= '0;
         held_q <= 1'b1;
         press  <= 1'b0;
      end else if (scnt_q == S_LAST) begin
         scnt_q <= '0;
         held_q <= key_up;
         press  <= held_q & ~key_up;
      end else begin
         scnt_q <= scnt_q + 1'b1;
         press  <= 1'b0;
      end
   end
endmodule

// File: rtl/sec_tally_phase.sv
module sec_tally_phase #(
   parameter int TICK_CYCLES = 50_000_000,
   localparam int PW = $clog2(TICK_CYCLES)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          restart,
   output logic [PW-1:0] phase,
   output logic          last
);
   localparam logic [PW-1:0] P_LAST = PW'(TICK_CYCLES - 1);

   assign last = (phase == P_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         phase <= '0;
      else if (restart || last)
         phase <= '0;
      else
         phase <= phase + 1'b1;
   end
endmodule

// File: rtl/sec_tally_bcd.sv
module sec_tally_bcd #(
   parameter int DIGITS = 6
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                inc_one,
   input  logic                inc_ten,
   output logic [4*DIGITS-1:0] digits
);
   logic [DIGITS-1:0] ripple;
   assign ripple[0] = inc_one;

   generate
      for (genvar i = 0; i < DIGITS; i++) begin : g_dig
         logic [3:0] d_q;
         logic       cin;
         if (i == 1) begin : g_tens
            assign cin = ripple[1] | inc_ten;
         end else begin : g_plain
            assign cin = ripple[i];
         end
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               d_q <= 4'd0;
            else if (cin)
               d_q <= (d_q == 4'd9) ? 4'd0 : d_q + 4'd1;
         end
         if (i < DIGITS - 1) begin : g_carry
            assign ripple[i+1] = cin & (d_q == 4'd9);
         end
         assign digits[4*i +: 4] = d_q;
      end
   endgenerate
endmodule

// File: rtl/sec_tally.sv
module sec_tally
   import sec_tally_pkg::*;
#(
   parameter int TICK_CYCLES    = 50_000_000,
   parameter int SAMPLE_CYCLES  = 1_000_000,
   parameter int DIGITS         = 6,
   parameter bit KEY_ACTIVE_LOW = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                key_pause,
   input  logic                key_add,
   output logic [4*DIGITS-1:0] count_bcd,
   output logic [3:0]          led
);
   localparam int PW = $clog2(TICK_CYCLES);
   localparam logic [PW-1:0] Q1 = PW'(TICK_CYCLES / 4);
   localparam logic [PW-1:0] Q2 = PW'(TICK_CYCLES / 2);
   localparam logic [PW-1:0] Q3 = PW'(3 * (TICK_CYCLES / 4));

   generate
      if (TICK_CYCLES < 8 || TICK_CYCLES % 4 != 0) begin : g_bad_tick
         $error("TICK_CYCLES must be a multiple of 4 and at least 8");
      end
      if (SAMPLE_CYCLES < 2) begin : g_bad_sample
         $error("SAMPLE_CYCLES must be at least 2");
      end
      if (DIGITS < 2) begin : g_bad_digits
         $error("DIGITS must be at least 2");
      end
   endgenerate

   logic          hit_pause, hit_add;
   logic [PW-1:0] phase;
   logic          phase_last;
   seq_e          seq_q;
   logic          paused_q, pend_q;
   logic          holding, start_hold, end_hold, inc_one;

   sec_tally_keysamp #(.SAMPLE_CYCLES(SAMPLE_CYCLES), .KEY_ACTIVE_LOW(KEY_ACTIVE_LOW)) u_kp (
      .clk(clk), .rst_n(rst_n), .key_raw(key_pause), .press(hit_pause));

   sec_tally_keysamp #(.SAMPLE_CYCLES(SAMPLE_CYCLES), .KEY_ACTIVE_LOW(KEY_ACTIVE_LOW)) u_ka (
      .clk(clk), .rst_n(rst_n), .key_raw(key_add), .press(hit_add));

   assign holding    = (seq_q == SEQ_HOLD);
   assign start_hold = !holding && hit_add;
   assign end_hold   = holding && phase_last;
   assign inc_one    = !holding && !paused_q && phase_last && !hit_add;

   sec_tally_phase #(.TICK_CYCLES(TICK_CYCLES)) u_phase (
      .clk(clk), .rst_n(rst_n), .restart(start_hold), .phase(phase), .last(phase_last));

   sec_tally_bcd #(.DIGITS(DIGITS)) u_bcd (
      .clk(clk), .rst_n(rst_n), .inc_one(inc_one), .inc_ten(end_hold), .digits(count_bcd));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seq_q    <= SEQ_FREE;
         paused_q <= 1'b0;
         pend_q   <= 1'b0;
      end else if (!holding) begin
         if (hit_pause) paused_q <= ~paused_q;
         if (hit_add) begin
            seq_q  <= SEQ_HOLD;
            pend_q <= 1'b0;
         end
      end else if (end_hold) begin
         seq_q    <= SEQ_FREE;
         paused_q <= paused_q ^ pend_q ^ hit_pause;
         pend_q   <= 1'b0;
      end else if (hit_pause) begin
         pend_q <= ~pend_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         led <= LAMPS_OFF;
      else if (paused_q || holding)
         led <= (phase >= Q2) ? LAMPS_ON : LAMPS_OFF;
      else if (phase < Q1)
         led <= 4'b0001;
      else if (phase < Q2)
         led <= 4'b0010;
      else if (phase < Q3)
         led <= 4'b0100;
      else
         led <= 4'b1000;
   end
endmodule

// File: rtl/sec_tally_chk.sv
module sec_tally_chk #(
   parameter int DIGITS = 6
) (
   input logic                clk,
   input logic                rst_n,
   input logic [4*DIGITS-1:0] count_bcd,
   input logic [3:0]          led,
   input logic                paused,
   input logic                holding,
   input logic                phase_last
);
   always @(posedge clk) begin
      if (!rst_n) begin
         a_r2_reset_clear: assert (count_bcd == '0 && led == 4'b0000)
            else $error("R2 reset state not clear");
      end
   end

   a_r4_frozen_paused: assert property (@(posedge clk) disable iff (!rst_n)
      (paused && !holding) |=> $stable(count_bcd));

   a_r7_hold_still: assert property (@(posedge clk) disable iff (!rst_n)
      (holding && !phase_last) |=> $stable(count_bcd));

   a_r7_hold_exit: assert property (@(posedge clk) disable iff (!rst_n)
      (holding && phase_last) |=> !holding);

   a_r5_walk_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      (!paused && !holding) |=> $onehot(led));

   a_r6_blink_all: assert property (@(posedge clk) disable iff (!rst_n)
      (paused || holding) |=> (led == 4'b0000 || led == 4'b1111));

   generate
      for (genvar i = 0; i < DIGITS; i++) begin : g_rng
         a_r1_digit_range: assert property (@(posedge clk) disable iff (!rst_n)
            count_bcd[4*i +: 4] <= 4'd9);
      end
   endgenerate
endmodule

bind sec_tally sec_tally_chk #(.DIGITS(DIGITS)) u_chk (
   .clk(clk), .rst_n(rst_n), .count_bcd(count_bcd), .led(led),
   .paused(paused_q), .holding(holding), .phase_last(phase_last));

// File: tb/sec_tally_test.sv
`timescale 1ns/1ps
module sec_tally_test;
   localparam int T = 40;
   localparam int S = 4;
   localparam int WATCHDOG = 150000;

   logic clk = 1'b0;
   logic rst_n = 1'b1;
   logic kp = 1'b1;
   logic ka = 1'b1;
   logic [23:0] cnt6;
   logic [7:0]  cnt2;
   logic [3:0]  led6, led2;

   always #4 clk = ~clk;

   sec_tally #(.TICK_CYCLES(T), .SAMPLE_CYCLES(S), .DIGITS(6)) uut (
      .clk(clk), .rst_n(rst_n), .key_pause(kp), .key_add(ka), .count_bcd(cnt6), .led(led6));

   sec_tally #(.TICK_CYCLES(T), .SAMPLE_CYCLES(S), .DIGITS(2)) uut_w (
      .clk(clk), .rst_n(rst_n), .key_pause(kp), .key_add(ka), .count_bcd(cnt2), .led(led2));

   // behavioural reference state
   int  m_sc, m_phase, m_val6, m_val2, since_add, glitch_left;
   bit  m_cur1, m_cur2, m_hit1, m_hit2, m_paused, m_hold, m_pend;
   int  m_led;
   string tag6, tag2, tagl;
   int  checks = 0, fails = 0, cycles = 0;
   bit  done = 0;

   function automatic logic [23:0] to_bcd(input int v, input int n);
      logic [23:0] r = '0;
      for (int i = 0; i < n; i++) begin
         r[4*i +: 4] = 4'(v % 10);
         v = v / 10;
      end
      return r;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_sc = 0; m_phase = 0; m_val6 = 0; m_val2 = 0;
         m_cur1 = 1; m_cur2 = 1; m_hit1 = 0; m_hit2 = 0;
         m_paused = 0; m_hold = 0; m_pend = 0; m_led = 0;
         since_add = 1000;
      end else begin
         bit h1, h2, last;
         int ph;
         h1 = m_hit1; h2 = m_hit2; ph = m_phase; last = (ph == T - 1);
         if (m_sc == S - 1) begin
            m_hit1 = m_cur1 && !kp; m_cur1 = kp;
            m_hit2 = m_cur2 && !ka; m_cur2 = ka;
            m_sc = 0;
         end else begin
            m_hit1 = 0; m_hit2 = 0; m_sc++;
         end
         m_led = (m_paused || m_hold) ? ((ph >= T/2) ? 15 : 0) : (1 << (ph / (T/4)));
         tagl  = (m_paused || m_hold) ? "R6" : "R5";
         tag6 = "R1"; tag2 = "R1";
         if (since_add < T + 2) begin tag6 = "R10"; tag2 = "R10"; end
         if (glitch_left > 0) begin tag6 = "R3"; tag2 = "R3"; end
         if (m_paused && !m_hold) begin tag6 = "R4"; tag2 = "R4"; end
         since_add++;
         if (!m_hold) begin
            if (!m_paused && last && !h2) begin
               m_val6 = (m_val6 + 1) % 1000000;
               if (m_val2 == 99) tag2 = "R9";
               m_val2 = (m_val2 + 1) % 100;
            end
            if (h1) m_paused = !m_paused;
            if (h2) begin m_hold = 1; m_pend = 0; m_phase = 0; end
            else m_phase = last ? 0 : ph + 1;
         end else begin
            tag6 = "R8"; tag2 = "R8";
            m_phase = last ? 0 : ph + 1;
            if (h1) m_pend = !m_pend;
            if (last) begin
               m_val6 = (m_val6 + 10) % 1000000;
               tag6 = "R7";
               tag2 = (m_val2 >= 90) ? "R9" : "R7";
               m_val2 = (m_val2 + 10) % 100;
               m_paused = m_paused ^ m_pend;
               m_pend = 0; m_hold = 0; since_add = 0;
            end
         end
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   always @(negedge clk) begin
      cycles++;
      if (glitch_left > 0) glitch_left--;
      if (!rst_n) begin
         checks++;
         if (cnt6 != 0 || led6 != 0 || cnt2 != 0) begin
            fails++;
            $display("FAIL R2 reset: count=%h led=%b count_w=%h expected all zero", cnt6, led6, cnt2);
         end
      end else begin
         logic [23:0] e6;
         logic [23:0] e2;
         e6 = to_bcd(m_val6, 6);
         e2 = to_bcd(m_val2, 2);
         checks++;
         if (cnt6 !== e6) begin
            fails++;
            $display("FAIL %s digits: actual=%h expected=%h", tag6, cnt6, e6);
         end
         checks++;
         if (cnt2 !== e2[7:0]) begin
            fails++;
            $display("FAIL %s digits(2-digit): actual=%h expected=%h", tag2, cnt2, e2[7:0]);
         end
         checks++;
         if (led6 !== 4'(m_led) || led2 !== 4'(m_led)) begin
            fails++;
            $display("FAIL %s lamps: actual=%b/%b expected=%b", tagl, led6, led2, 4'(m_led));
         end
      end
      if (cycles > WATCHDOG) begin
         fails++;
         $display("FAIL watchdog: actual=%0d cycles expected<=%0d", cycles, WATCHDOG);
         finish_run();
      end
   end

   task automatic wait_cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic press_pause();
      kp = 1'b0; wait_cyc(3*S); kp = 1'b1; wait_cyc(3*S);
   endtask

   task automatic press_add();
      ka = 1'b0; wait_cyc(3*S); ka = 1'b1; wait_cyc(3*S);
   endtask

   initial begin
      #2 rst_n = 1'b0;                 // R2 reset held
      wait_cyc(5);
      rst_n = 1'b1;
      wait_cyc(500);                   // R1 counting with 9->10 carry, R5 walk
      // R3: one-clock pulse strictly between samples
      while (m_sc != 0) wait_cyc(1);
      glitch_left = 2*T;
      kp = 1'b0; wait_cyc(1); kp = 1'b1;
      wait_cyc(2*T);
      press_pause();                   // R4 freeze, R6 blink
      wait_cyc(200);
      press_pause();                   // resume
      wait_cyc(100);
      press_add();                     // R7 from counting
      wait_cyc(4);
      press_add();                     // R8 ignored
      press_pause();                   // R8 deferred toggle
      wait_cyc(150);                   // R10 restart after add
      press_add();                     // R7 from frozen
      wait_cyc(120);
      press_pause();                   // back to counting
      while (!(m_val2 >= 90 && m_val2 <= 97 && !m_hold && !m_paused)) wait_cyc(1);
      press_add();                     // R9 wrap by add of ten
      wait_cyc(2*T);
      while (m_val2 != 2) wait_cyc(1); // R9 wrap by single steps
      wait_cyc(3*T);
      finish_run();
   end
endmodule